// File: doc/BRIEF.md
# Receive Squelch Activity Qualifier

This block decides whether a digitized receive line carries real data and gates the receive output driver. Its inputs come from analog stages outside the block: a 1-bit sliced receive level, and a flag from a DC-level comparator. Both are sampled on a fast oversampling clock, for example 200 MHz. The block works from their digital results only.

Three conditions must hold at once to qualify activity. The average DC level must be reported good. Narrow pulses are rejected before they can count as transitions. Qualified transitions must keep arriving within a maximum gap. The block outputs a data-valid flag, a drive-enable and a gated data bit. When data is not valid, the drive-enable is low. This is the zero-differential idle state, which is kept distinct from a logic 0 on the data bit.

Two parameters set the thresholds, both counted in sample-clock cycles. `MIN_PULSE_CYC` is the shortest accepted pulse, and `MAX_GAP_CYC` is the longest allowed gap between transitions. Their defaults are 4 and 40 cycles, which correspond to 20 ns and 200 ns at 200 MHz.

Top module: `rx_squelch_qual`

## Requirements
- R1: While `rx_level_ok` is sampled low, `rx_valid` is low after that clock edge. A transition accepted while `rx_level_ok` is low does not raise `rx_valid`.
- R2: A run of the sliced input that lasts fewer than `MIN_PULSE_CYC` consecutive samples at the opposite level is ignored. It does not change the filtered level, does not raise `rx_valid`, and does not change `rx_data`.
- R3: When the sliced input holds the opposite level for `MIN_PULSE_CYC` consecutive samples, the filtered level changes at the edge that takes the last of those samples. On that same edge, `rx_valid` rises if `rx_level_ok` is high.
- R4: `rx_valid` stays high without a break as long as accepted transitions follow each other at most `MAX_GAP_CYC` cycles apart and `rx_level_ok` stays high.
- R5: Suppose an accepted transition is taken at edge e and none follows. Then `rx_valid` is high for edges e through e+`MAX_GAP_CYC`-1 and low from edge e+`MAX_GAP_CYC` on.
- R6: There is no inversion. While valid, `rx_data` equals the filtered level, so a high sliced input gives `rx_data` = 1.
- R7: `rx_drive_en` equals `rx_valid`. When it is low, the line is idle and `rx_data` is forced to 0.
- R8: A synchronous active-high `rst` clears `rx_valid`, `rx_drive_en` and `rx_data`, and sets the filtered level to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_slice | input | 1 | Sliced receive level, 1 = high line |
| rx_level_ok | input | 1 | DC-level comparator result, 1 = level good |
| rx_valid | output | 1 | Receive activity qualified |
| rx_drive_en | output | 1 | Output driver enable; 0 = zero-differential idle |
| rx_data | output | 1 | Gated receive data bit |

## Verification
The assertions take for granted two properties of the inputs:
- `rx_slice` and `rx_level_ok` are already synchronous to `clk`. No stage here resynchronizes them.
- Reset is held for at least two cycles, so that `$past` terms never reach back to pre-reset values.

The stimulus respects both. It changes the inputs only on the falling clock edge and holds `rst` for several cycles at start-up and again mid-stream. The stimulus sweeps the following:
- pulse widths across the reject threshold;
- transition spacings a few cycles either side of the gap limit;
- level-flag drops in the middle of a stream;
- Manchester-style streams at several bit rates.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

    localparam int unsigned RSQ_DEF_MIN_PULSE = 4;
    localparam int unsigned RSQ_DEF_MAX_GAP   = 40;

    typedef struct packed {
        logic level;
        logic accept;
    } rsq_filt_t;

    typedef struct packed {
        logic drive_en;
        logic data;
    } rsq_line_t;

    function automatic rsq_line_t rsq_gate(input logic valid, input logic level);
        rsq_line_t l;
        l.drive_en = valid;
        l.data     = valid & level;
        return l;
    endfunction

endpackage

// File: rtl/rsq_pulse_filter.sv
module rsq_pulse_filter
    import rsq_pkg::*;
#(
    parameter int unsigned MIN_PULSE_CYC = RSQ_DEF_MIN_PULSE
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      raw,
    output rsq_filt_t filt
);

    localparam int unsigned CW = (MIN_PULSE_CYC > 1) ? $clog2(MIN_PULSE_CYC) : 1;

    logic level_q;
    logic accept;

    generate
        if (MIN_PULSE_CYC > 1) begin : g_run
            logic [CW-1:0] run_q;
            assign accept = (raw != level_q) && (run_q == CW'(MIN_PULSE_CYC - 1));
            always_ff @(posedge clk) begin
                if (rst || raw == level_q || accept) begin
                    run_q <= '0;
                end else begin
                    run_q <= run_q + CW'(1);
                end
            end
        end else begin : g_direct
            assign accept = (raw != level_q);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q <= 1'b0;
        end else if (accept) begin
            level_q <= raw;
        end
    end

    assign filt.level  = level_q;
    assign filt.accept = accept;

    // R3: a change of the filtered level always adopts the sampled input
    p_level_follows_raw_r3: assert property (@(posedge clk) disable iff (rst)
        (level_q != $past(level_q)) |-> (level_q == $past(raw)));

    // R2: a sample that agrees with the filtered level never moves it
    p_agree_holds_r2: assert property (@(posedge clk) disable iff (rst)
        ($past(raw) == $past(level_q)) |-> $stable(level_q));

endmodule

// File: rtl/rsq_gap_timer.sv
module rsq_gap_timer
    import rsq_pkg::*;
#(
    parameter int unsigned MAX_GAP_CYC = RSQ_DEF_MAX_GAP
) (
    input  logic clk,
    input  logic rst,
    input  logic trans_in,
    input  logic level_ok,
    output logic valid
);

    localparam int unsigned GW = $clog2(MAX_GAP_CYC + 1);
    localparam logic [GW-1:0] GAP_SAT  = GW'(MAX_GAP_CYC);
    localparam logic [GW-1:0] GAP_LAST = GW'(MAX_GAP_CYC - 1);

    logic [GW-1:0] gap_q;
    logic          valid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q <= GAP_SAT;
        end else if (trans_in) begin
            gap_q <= '0;
        end else if (gap_q != GAP_SAT) begin
            gap_q <= gap_q + GW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
        end else if (!level_ok) begin
            valid_q <= 1'b0;
        end else if (trans_in) begin
            valid_q <= 1'b1;
        end else if (gap_q >= GAP_LAST) begin
            valid_q <= 1'b0;
        end
    end

    assign valid = valid_q;

    // R3: valid only rises on an accepted transition with good level
    p_rise_needs_transition_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(valid_q) |-> ($past(trans_in) && $past(level_ok)));

    // R1: a low level flag clears valid on the next edge
    p_level_low_clears_r1: assert property (@(posedge clk) disable iff (rst)
        !level_ok |=> !valid_q);

    // R5: the last allowed quiet cycle without a transition ends validity
    p_gap_expiry_r5: assert property (@(posedge clk) disable iff (rst)
        (valid_q && !trans_in && gap_q == GAP_LAST) |=> !valid_q);

    // R4: while valid the quiet count never reaches the limit
    p_gap_bound_r4: assert property (@(posedge clk) disable iff (rst)
        valid_q |-> (gap_q < GAP_SAT));

endmodule

// File: rtl/rx_squelch_qual.sv
module rx_squelch_qual
    import rsq_pkg::*;
#(
    parameter int unsigned MIN_PULSE_CYC = RSQ_DEF_MIN_PULSE,
    parameter int unsigned MAX_GAP_CYC   = RSQ_DEF_MAX_GAP
) (
    input  logic clk,
    input  logic rst,
    input  logic rx_slice,
    input  logic rx_level_ok,
    output logic rx_valid,
    output logic rx_drive_en,
    output logic rx_data
);

    rsq_filt_t filt;
    logic      valid;
    rsq_line_t line;

    rsq_pulse_filter #(
        .MIN_PULSE_CYC(MIN_PULSE_CYC)
    ) u_filter (
        .clk (clk),
        .rst (rst),
        .raw (rx_slice),
        .filt(filt)
    );

    rsq_gap_timer #(
        .MAX_GAP_CYC(MAX_GAP_CYC)
    ) u_gap (
        .clk     (clk),
        .rst     (rst),
        .trans_in(filt.accept),
        .level_ok(rx_level_ok),
        .valid   (valid)
    );

    assign line        = rsq_gate(valid, filt.level);
    assign rx_valid    = valid;
    assign rx_drive_en = line.drive_en;
    assign rx_data     = line.data;

    // R7: idle line never presents a data 1
    p_idle_zero_r7: assert property (@(posedge clk) disable iff (rst)
        !rx_drive_en |-> !rx_data);

    // R8: one edge after reset the line is idle
    p_reset_idle_r8: assert property (@(posedge clk)
        $past(rst) |-> (!rx_valid && !rx_drive_en && !rx_data));

endmodule

// File: tb/rx_squelch_qual_bench.sv
module rx_squelch_qual_bench;

    localparam int P = 4;
    localparam int G = 40;
    localparam time CLK_PERIOD = 5ns;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rx_slice = 1'b0;
    logic rx_level_ok = 1'b0;
    logic rx_valid, rx_drive_en, rx_data;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    string cur_req = "R8";

    // reference model state
    logic ef;
    logic hist [0:P-1];
    int n, last_edge, last_low;
    bit have_edge, primed;
    logic ev;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rx_squelch_qual #(.MIN_PULSE_CYC(P), .MAX_GAP_CYC(G)) u_rx_squelch_qual (
        .clk(clk), .rst(rst), .rx_slice(rx_slice), .rx_level_ok(rx_level_ok),
        .rx_valid(rx_valid), .rx_drive_en(rx_drive_en), .rx_data(rx_data)
    );

    task automatic check_bit(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at %0t: actual=%b expected=%b", tag, $time, act, exp);
        end
    endtask

    task automatic compare();
        if (primed) begin
            check_bit({cur_req, " valid"}, rx_valid, ev);
            check_bit("R7 drive_en", rx_drive_en, ev);
            check_bit({cur_req, " data"}, rx_data, ev & ef);
        end
    endtask

    task automatic model_reset();
        ef = 1'b0; n = -1; last_edge = -1; last_low = -1; have_edge = 0; ev = 1'b0;
        for (int i = 0; i < P; i++) hist[i] = 1'b0;
        primed = 1;
    endtask

    task automatic model_sample(input logic b, input logic l);
        bit all;
        n++;
        for (int i = P - 1; i > 0; i--) hist[i] = hist[i-1];
        hist[0] = b;
        if (n >= P - 1) begin
            all = 1;
            for (int i = 0; i < P; i++) if (hist[i] == ef) all = 0;
            if (all) begin
                ef = ~ef; last_edge = n; have_edge = 1;
            end
        end
        if (!l) last_low = n;
        ev = (have_edge && (n - last_edge < G) && (last_low < last_edge)) ? 1'b1 : 1'b0;
    endtask

    task automatic do_reset(input int k);
        for (int i = 0; i < k; i++) begin
            @(negedge clk);
            compare();
            rst = 1'b1;
            model_reset();
        end
    endtask

    task automatic step(input logic b, input logic l);
        @(negedge clk);
        compare();
        rst = 1'b0; rx_slice = b; rx_level_ok = l;
        model_sample(b, l);
    endtask

    task automatic hold(input logic b, input logic l, input int k);
        for (int i = 0; i < k; i++) step(b, l);
    endtask

    task automatic manch(input int half, input int nbits, input int seed);
        for (int i = 0; i < nbits; i++) begin
            logic bv;
            bv = (((i * 7 + seed) % 5) < 2) ? 1'b1 : 1'b0;
            hold(~bv, 1'b1, half);
            hold(bv, 1'b1, half);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        primed = 0;
        cur_req = "R8";
        do_reset(4);
        hold(1'b0, 1'b1, 10);

        // R2: pulses shorter than the minimum, from idle and inside data
        cur_req = "R2";
        for (int w = 1; w < P; w++) begin
            hold(1'b1, 1'b1, w);
            hold(1'b0, 1'b1, 20);
        end
        for (int w = 1; w < P; w++) begin
            hold(1'b1, 1'b1, 12);
            hold(1'b0, 1'b1, w);
            hold(1'b1, 1'b1, 12);
            hold(1'b0, 1'b1, 12);
        end
        hold(1'b0, 1'b1, G + 5);

        // R3: pulses at and just above the minimum are accepted
        cur_req = "R3";
        for (int w = P; w <= P + 2; w++) begin
            hold(1'b1, 1'b1, w);
            hold(1'b0, 1'b1, w);
            hold(1'b0, 1'b1, G + 3);
        end

        // R6: Manchester streams at several bit rates
        cur_req = "R6";
        manch(5, 20, 0);
        manch(10, 16, 3);
        manch(20, 8, 1);
        hold(1'b1, 1'b1, G + 5);

        // R4 / R5: transition spacing around the gap limit
        for (int s = G - 2; s <= G + 2; s++) begin
            cur_req = (s <= G) ? "R4" : "R5";
            hold(1'b0, 1'b1, s);
            hold(1'b1, 1'b1, s);
            hold(1'b0, 1'b1, s);
            hold(1'b0, 1'b1, G + 5);
        end

        // R1: level flag drops mid-stream and transitions with bad level
        cur_req = "R1";
        hold(1'b1, 1'b1, 10);
        hold(1'b0, 1'b1, 10);
        hold(1'b1, 1'b0, 10);
        hold(1'b0, 1'b0, 10);
        hold(1'b1, 1'b1, 3);
        hold(1'b1, 1'b1, 10);
        hold(1'b0, 1'b1, 10);
        hold(1'b0, 1'b0, 1);
        hold(1'b0, 1'b1, 20);
        hold(1'b1, 1'b1, G + 5);

        // R8: reset in the middle of activity
        cur_req = "R6";
        manch(10, 6, 2);
        cur_req = "R8";
        do_reset(3);
        hold(1'b1, 1'b1, 2);
        hold(1'b0, 1'b1, 10);
        cur_req = "R6";
        manch(8, 6, 4);
        hold(1'b0, 1'b1, G + 5);
        @(negedge clk);
        compare();

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule